// File: doc/BRIEF.md
# USB Host Controller Run/Reset Control Register Unit

This unit holds the software-visible control state of a USB host controller: the command register, the status register, the command ring control register, the interrupter management register and the event ring dequeue register. Software writes arrive on a simple single-cycle write strobe with a register select. Reads are combinational from a separate select. The unit decodes run/stop, controller reset and interrupter enable. It drives the pointers and flags that the ring engines downstream consume.

Stopping and resetting the controller are not instant. Both hand a "stop all slots" request to the slot logic and wait for its done pulse. Only then does the status register report halted, or drop controller-not-ready. A single request is outstanding at any moment, and one later request can wait in a queue slot behind it. The command ring pointer is protected: while the ring runs, software cannot move it.

Register selects are 0 for command, 1 for status, 2 for command ring control, 3 for interrupter management and 4 for event ring dequeue.

Top module: `usbhc_runctl`

## Requirements
- R1: After synchronous reset, the status register reads halted (bit 0) = 1 and controller-not-ready (bit 1) = 0. The command register reads 0, stop_req = 0 and intr_en = 0.
- R2: A command write with bit 1 (reset) set sets controller-not-ready on the next cycle and raises stop_req with stop_reset = 1. The command register keeps its old value, and its reset bit always reads 0. No other bit of that write is stored or acted on.
- R3: Controller-not-ready clears only on the cycle after stop_done completes an outstanding reset request.
- R4: A command write with reset clear stores run (bit 0) and interrupter enable (bit 2). If run is 1, halted clears on the next cycle. If run is 0, the write clears command-ring-running and raises stop_req with stop_reset = 0, while halted stays unchanged.
- R5: Halted sets on the cycle after stop_done completes a halt request. If a command write with run = 1 lands in that same cycle, halted stays 0.
- R6: intr_en equals command bit 2 AND interrupter management bit 1. It is updated on the cycle after a write to either register, and a reset write leaves it unchanged.
- R7: A command ring control write while not running loads the pointer from bits 63:6 (bits 5:0 read 0) and the cycle state from bit 0. While running, the write is discarded. The register reads pointer | running in bit 3 | cycle in bit 0.
- R8: A ring_start pulse sets command-ring-running only while run is 1. Running never sets through a register write.
- R9: An event ring dequeue write loads the pointer from bits 63:4 and event-handler-busy from bit 3. Both are visible on er_deq_ptr and er_busy, and the register reads back as pointer | busy in bit 3.
- R10: Only one stop request is outstanding at a time, and its kind holds until stop_done. A request arriving meanwhile is queued, and a queued reset is not replaced by a later halt. After stop_done, stop_req is low for one cycle, then the queued request is issued.
- R11: stop_done with no outstanding request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 64 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 64 | Read data, combinational |
| ring_start | input | 1 | Command ring start pulse from doorbell decode |
| stop_req | output | 1 | Stop-all-slots request, held until done |
| stop_reset | output | 1 | 1 when the outstanding request is a reset, 0 for a halt |
| stop_done | input | 1 | Slot logic reports the request complete |
| intr_en | output | 1 | Interrupter enable |
| cr_deq_ptr | output | 64 | Command ring dequeue pointer |
| cr_cycle | output | 1 | Command ring consumer cycle state |
| cr_running | output | 1 | Command ring running |
| er_deq_ptr | output | 64 | Event ring dequeue pointer |
| er_busy | output | 1 | Event handler busy |

## Verification
Two functions can meet in one cycle. The first is completing a halt through stop_done, and the second is a software write that sets run again. The bench starts a halt and then drives the run write and the done pulse on the same edge. It checks that halted stays 0, that stop_req drops, and that run reads back 1. A second collision is a new reset arriving while a halt is outstanding. The bench checks that the reset waits, survives a later halt write, and is issued after one idle cycle.

// File: rtl/usbhc_runctl_pkg.sv
package usbhc_runctl_pkg;

    localparam int REG_W = 64;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD = 3'd0,
        SEL_STS = 3'd1,
        SEL_CRC = 3'd2,
        SEL_IMG = 3'd3,
        SEL_ERD = 3'd4
    } reg_sel_e;

    // command register fields
    localparam int CMD_RUN = 0;
    localparam int CMD_RST = 1;
    localparam int CMD_IEN = 2;
    // status register fields
    localparam int STS_HLT = 0;
    localparam int STS_CNR = 1;
    // command ring control fields
    localparam int CRC_CYC = 0;
    localparam int CRC_RUN = 3;
    // interrupter management field
    localparam int IMG_IE  = 1;
    // event ring dequeue field
    localparam int ERD_BSY = 3;

    typedef enum logic {
        KIND_HALT  = 1'b0,
        KIND_RESET = 1'b1
    } stop_kind_e;

    typedef struct packed {
        logic       valid;
        stop_kind_e kind;
    } stop_slot_t;

    function automatic logic [REG_W-1:0] align_down(input logic [REG_W-1:0] v, input int lsb);
        return (v >> lsb) << lsb;
    endfunction

    // a waiting reset is never downgraded by a later halt
    function automatic stop_kind_e merge_kind(input stop_slot_t q, input stop_kind_e k);
        return (q.valid && q.kind == KIND_RESET) ? KIND_RESET : k;
    endfunction

endpackage

// File: rtl/usbhc_stopseq.sv
module usbhc_stopseq
    import usbhc_runctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       new_v,
    input  stop_kind_e new_k,
    input  logic       done_i,
    output logic       req_o,
    output stop_kind_e kind_o,
    output logic       fin_halt_o,
    output logic       fin_reset_o
);

    stop_slot_t act_q;
    stop_slot_t que_q;
    logic       fin;

    assign fin = done_i & act_q.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            que_q <= '0;
        end else if (act_q.valid) begin
            if (fin) act_q.valid <= 1'b0;
            if (new_v) begin
                que_q.valid <= 1'b1;
                que_q.kind  <= merge_kind(que_q, new_k);
            end
        end else if (que_q.valid) begin
            act_q       <= que_q;
            que_q.valid <= new_v;
            que_q.kind  <= new_k;
        end else if (new_v) begin
            act_q.valid <= 1'b1;
            act_q.kind  <= new_k;
        end
    end

    assign req_o       = act_q.valid;
    assign kind_o      = act_q.kind;
    assign fin_halt_o  = fin && act_q.kind == KIND_HALT;
    assign fin_reset_o = fin && act_q.kind == KIND_RESET;

    // R10: request drops for a cycle after completion
    assert_drop_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        (done_i && req_o) |=> !req_o);

    // R10: an outstanding request and its kind hold until done
    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (req_o && !done_i) |=> (req_o && kind_o == $past(kind_o)));

    // R11: done with nothing outstanding starts nothing and finishes nothing
    assert_spurious_done_R11: assert property (@(posedge clk) disable iff (rst)
        (!req_o && !que_q.valid && !new_v) |=> !req_o);

endmodule

// File: rtl/usbhc_cmdsts.sv
module usbhc_cmdsts
    import usbhc_runctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fin_halt,
    input  logic             fin_reset,
    output logic             run_o,
    output logic             ien_o,
    output logic             halted_o,
    output logic             cnr_o,
    output logic             new_v,
    output stop_kind_e       new_k,
    output logic             ring_stop_o
);

    logic rst_wr;
    logic run_wr;
    logic halt_wr;

    always_comb begin
        rst_wr  = wr_cmd && wr_data[CMD_RST];
        run_wr  = wr_cmd && !wr_data[CMD_RST] && wr_data[CMD_RUN];
        halt_wr = wr_cmd && !wr_data[CMD_RST] && !wr_data[CMD_RUN];
        new_v   = rst_wr || halt_wr;
        new_k   = rst_wr ? KIND_RESET : KIND_HALT;
        ring_stop_o = halt_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_o    <= 1'b0;
            ien_o    <= 1'b0;
            halted_o <= 1'b1;
            cnr_o    <= 1'b0;
        end else begin
            if (fin_halt && !run_wr) halted_o <= 1'b1;
            if (run_wr)              halted_o <= 1'b0;
            if (fin_reset)           cnr_o    <= 1'b0;
            if (rst_wr)              cnr_o    <= 1'b1;
            if (wr_cmd && !wr_data[CMD_RST]) begin
                run_o <= wr_data[CMD_RUN];
                ien_o <= wr_data[CMD_IEN];
            end
        end
    end

    // R2: not-ready only rises from a reset write
    assert_cnr_from_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cnr_o) |-> $past(rst_wr));

    // R2: a reset write leaves the stored command bits alone
    assert_rst_keeps_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        rst_wr |=> ($stable(run_o) && $stable(ien_o)));

    // R3: not-ready only falls on reset completion
    assert_cnr_clear_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cnr_o) |-> $past(fin_reset));

    // R5: halted only rises on halt completion
    assert_halt_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(halted_o) |-> $past(fin_halt));

endmodule

// File: rtl/usbhc_ringregs.sv
module usbhc_ringregs
    import usbhc_runctl_pkg::*;
#(
    parameter int CR_ALIGN = 6,
    parameter int ER_ALIGN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_crc,
    input  logic             wr_erd,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ring_start,
    input  logic             run,
    input  logic             ring_stop,
    output logic [REG_W-1:0] cr_ptr,
    output logic             cr_cyc,
    output logic             cr_run,
    output logic [REG_W-1:0] er_ptr,
    output logic             er_bsy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_ptr <= '0;
            cr_cyc <= 1'b0;
            cr_run <= 1'b0;
            er_ptr <= '0;
            er_bsy <= 1'b0;
        end else begin
            if (wr_crc && !cr_run) begin
                cr_ptr <= align_down(wr_data, CR_ALIGN);
                cr_cyc <= wr_data[CRC_CYC];
            end
            if (ring_stop)                cr_run <= 1'b0;
            else if (ring_start && run)   cr_run <= 1'b1;
            if (wr_erd) begin
                er_ptr <= align_down(wr_data, ER_ALIGN);
                er_bsy <= wr_data[ERD_BSY];
            end
        end
    end

    // R7: a write while running is discarded
    assert_crc_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_crc && cr_run) |=> ($stable(cr_ptr) && $stable(cr_cyc)));

    // R8: running only starts from a start pulse while run is set
    assert_start_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(cr_run) |-> $past(ring_start && run));

    // R9: busy flag follows the written bit
    assert_erd_busy_R9: assert property (@(posedge clk) disable iff (rst)
        wr_erd |=> (er_bsy == $past(wr_data[ERD_BSY])));

endmodule

// File: rtl/usbhc_intr.sv
module usbhc_intr
    import usbhc_runctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic             wr_img,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ien,
    output logic             img_ie,
    output logic             intr_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            img_ie  <= 1'b0;
            intr_en <= 1'b0;
        end else begin
            if (wr_img) begin
                img_ie  <= wr_data[IMG_IE];
                intr_en <= wr_data[IMG_IE] & ien;
            end
            if (wr_cmd && !wr_data[CMD_RST]) begin
                intr_en <= wr_data[CMD_IEN] & img_ie;
            end
        end
    end

    // R6: after a write to either source, the output matches both stored bits
    assert_intr_and_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_img || wr_cmd) |=> (intr_en == (ien & img_ie)));

    // R6: without a write the output does not move
    assert_intr_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_img && !wr_cmd) |=> $stable(intr_en));

endmodule

// File: rtl/usbhc_runctl.sv
module usbhc_runctl
    import usbhc_runctl_pkg::*;
#(
    parameter int CR_ALIGN = 6,
    parameter int ER_ALIGN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [63:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [63:0] rd_data,
    input  logic        ring_start,
    output logic        stop_req,
    output logic        stop_reset,
    input  logic        stop_done,
    output logic        intr_en,
    output logic [63:0] cr_deq_ptr,
    output logic        cr_cycle,
    output logic        cr_running,
    output logic [63:0] er_deq_ptr,
    output logic        er_busy
);

    logic       wr_cmd, wr_crc, wr_img, wr_erd;
    logic       run, ien, halted, cnr, img_ie;
    logic       new_v, ring_stop, fin_halt, fin_reset;
    stop_kind_e new_k, act_k;

    always_comb begin
        wr_cmd = wr_en && reg_sel_e'(wr_sel) == SEL_CMD;
        wr_crc = wr_en && reg_sel_e'(wr_sel) == SEL_CRC;
        wr_img = wr_en && reg_sel_e'(wr_sel) == SEL_IMG;
        wr_erd = wr_en && reg_sel_e'(wr_sel) == SEL_ERD;
    end

    usbhc_cmdsts u_cmd (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .fin_halt(fin_halt), .fin_reset(fin_reset),
        .run_o(run), .ien_o(ien), .halted_o(halted), .cnr_o(cnr),
        .new_v(new_v), .new_k(new_k), .ring_stop_o(ring_stop)
    );

    usbhc_stopseq u_seq (
        .clk(clk), .rst(rst), .new_v(new_v), .new_k(new_k), .done_i(stop_done),
        .req_o(stop_req), .kind_o(act_k),
        .fin_halt_o(fin_halt), .fin_reset_o(fin_reset)
    );

    usbhc_ringregs #(.CR_ALIGN(CR_ALIGN), .ER_ALIGN(ER_ALIGN)) u_ring (
        .clk(clk), .rst(rst), .wr_crc(wr_crc), .wr_erd(wr_erd), .wr_data(wr_data),
        .ring_start(ring_start), .run(run), .ring_stop(ring_stop),
        .cr_ptr(cr_deq_ptr), .cr_cyc(cr_cycle), .cr_run(cr_running),
        .er_ptr(er_deq_ptr), .er_bsy(er_busy)
    );

    usbhc_intr u_intr (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_img(wr_img), .wr_data(wr_data),
        .ien(ien), .img_ie(img_ie), .intr_en(intr_en)
    );

    assign stop_reset = stop_req && act_k == KIND_RESET;

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_CMD: begin
                rd_data[CMD_RUN] = run;
                rd_data[CMD_IEN] = ien;
            end
            SEL_STS: begin
                rd_data[STS_HLT] = halted;
                rd_data[STS_CNR] = cnr;
            end
            SEL_CRC: begin
                rd_data          = cr_deq_ptr;
                rd_data[CRC_CYC] = cr_cycle;
                rd_data[CRC_RUN] = cr_running;
            end
            SEL_IMG: rd_data[IMG_IE] = img_ie;
            SEL_ERD: begin
                rd_data          = er_deq_ptr;
                rd_data[ERD_BSY] = er_busy;
            end
            default: rd_data = '0;
        endcase
    end

    // R4: a halt write drops the ring-running flag at once
    assert_halt_stops_ring_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !wr_data[CMD_RST] && !wr_data[CMD_RUN]) |=> !cr_running);

endmodule

// File: tb/sim_usbhc_runctl.sv
module sim_usbhc_runctl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        ring_start = 1'b0;
    logic        stop_req, stop_reset;
    logic        stop_done = 1'b0;
    logic        intr_en;
    logic [63:0] cr_deq_ptr, er_deq_ptr;
    logic        cr_cycle, cr_running, er_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    usbhc_runctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ring_start(ring_start),
        .stop_req(stop_req), .stop_reset(stop_reset), .stop_done(stop_done),
        .intr_en(intr_en), .cr_deq_ptr(cr_deq_ptr), .cr_cycle(cr_cycle),
        .cr_running(cr_running), .er_deq_ptr(er_deq_ptr), .er_busy(er_busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, input string tag, input logic [63:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        stop_done = 1'b1;
        @(negedge clk);
        stop_done = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        rd(3'd1, "R1 status", 64'h1);
        rd(3'd0, "R1 command", 64'h0);
        chk("R1 stop_req", {63'd0, stop_req}, 64'd0);
        chk("R1 intr_en", {63'd0, intr_en}, 64'd0);
    endtask

    task automatic t_run_intr();
        wr(3'd0, 64'h5);
        rd(3'd0, "R4 command run+ien", 64'h5);
        rd(3'd1, "R4 halted cleared", 64'h0);
        chk("R6 intr_en needs mgmt bit", {63'd0, intr_en}, 64'd0);
        wr(3'd3, 64'h2);
        chk("R6 intr_en both set", {63'd0, intr_en}, 64'd1);
        rd(3'd3, "R6 mgmt readback", 64'h2);
        wr(3'd3, 64'h0);
        chk("R6 intr_en mgmt clear", {63'd0, intr_en}, 64'd0);
        wr(3'd3, 64'h2);
        chk("R6 intr_en mgmt set again", {63'd0, intr_en}, 64'd1);
    endtask

    task automatic t_crc_guard();
        wr(3'd2, 64'h1234_5678_9ABC_DEFF);
        chk("R7 ptr loaded", cr_deq_ptr, 64'h1234_5678_9ABC_DEC0);
        chk("R7 cycle loaded", {63'd0, cr_cycle}, 64'd1);
        rd(3'd2, "R7 crc readback", 64'h1234_5678_9ABC_DEC1);
        chk("R8 not running by write", {63'd0, cr_running}, 64'd0);
        @(negedge clk); ring_start = 1'b1;
        @(negedge clk); ring_start = 1'b0;
        chk("R8 start while run", {63'd0, cr_running}, 64'd1);
        wr(3'd2, 64'h0);
        chk("R7 ptr kept while running", cr_deq_ptr, 64'h1234_5678_9ABC_DEC0);
        rd(3'd2, "R7 crc readback running", 64'h1234_5678_9ABC_DEC9);
    endtask

    task automatic t_erd();
        wr(3'd4, 64'hFEDC_BA98_7654_321F);
        chk("R9 er ptr", er_deq_ptr, 64'hFEDC_BA98_7654_3210);
        chk("R9 er busy", {63'd0, er_busy}, 64'd1);
        rd(3'd4, "R9 erd readback", 64'hFEDC_BA98_7654_3218);
        wr(3'd4, 64'h40);
        chk("R9 er ptr 2", er_deq_ptr, 64'h40);
        chk("R9 er busy clear", {63'd0, er_busy}, 64'd0);
    endtask

    task automatic t_halt();
        wr(3'd0, 64'h0);
        chk("R4 ring stopped", {63'd0, cr_running}, 64'd0);
        chk("R4 halt request", {62'd0, stop_req, stop_reset}, 64'h2);
        chk("R6 intr_en follows cmd write", {63'd0, intr_en}, 64'd0);
        tick(); tick(); tick();
        rd(3'd1, "R4 halted waits for done", 64'h0);
        pulse_done();
        rd(3'd1, "R5 halted on done", 64'h1);
        chk("R10 request dropped", {63'd0, stop_req}, 64'd0);
    endtask

    task automatic t_start_halted();
        @(negedge clk); ring_start = 1'b1;
        @(negedge clk); ring_start = 1'b0;
        chk("R8 no start when stopped", {63'd0, cr_running}, 64'd0);
    endtask

    task automatic t_ctrl_reset();
        wr(3'd0, 64'h7);
        rd(3'd1, "R2 not-ready set, halted kept", 64'h3);
        rd(3'd0, "R2 command unchanged", 64'h0);
        chk("R2 reset request", {62'd0, stop_req, stop_reset}, 64'h3);
        chk("R2 intr_en unchanged", {63'd0, intr_en}, 64'd0);
        tick(); tick();
        rd(3'd1, "R3 not-ready held", 64'h3);
        pulse_done();
        rd(3'd1, "R3 not-ready cleared", 64'h1);
        chk("R3 request dropped", {63'd0, stop_req}, 64'd0);
    endtask

    task automatic t_spurious();
        pulse_done();
        tick();
        rd(3'd1, "R11 status unchanged", 64'h1);
        chk("R11 no request", {63'd0, stop_req}, 64'd0);
    endtask

    task automatic t_queue();
        wr(3'd0, 64'h1);
        wr(3'd0, 64'h0);
        chk("R10 halt active", {62'd0, stop_req, stop_reset}, 64'h2);
        wr(3'd0, 64'h2);
        chk("R10 active kind kept", {62'd0, stop_req, stop_reset}, 64'h2);
        rd(3'd1, "R10 not-ready set at once", 64'h2);
        wr(3'd0, 64'h0);
        pulse_done();
        chk("R10 gap after done", {63'd0, stop_req}, 64'd0);
        rd(3'd1, "R10 halted, reset pending", 64'h3);
        tick();
        chk("R10 queued reset issued", {62'd0, stop_req, stop_reset}, 64'h3);
        pulse_done();
        rd(3'd1, "R10 reset done", 64'h1);
        tick(); tick();
        chk("R10 nothing more queued", {63'd0, stop_req}, 64'd0);
    endtask

    task automatic t_done_vs_run();
        wr(3'd0, 64'h1);
        wr(3'd0, 64'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 64'h1; stop_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; stop_done = 1'b0;
        rd(3'd1, "R5 run write beats completion", 64'h0);
        chk("R5 request dropped", {63'd0, stop_req}, 64'd0);
        rd(3'd0, "R5 run stored", 64'h1);
        tick();
        rd(3'd1, "R5 halted stays clear", 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_run_intr();
        t_crc_guard();
        t_erd();
        t_halt();
        t_start_halted();
        t_ctrl_reset();
        t_spurious();
        t_queue();
        t_done_vs_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule